// File: doc/BRIEF.md
# Real-time clock snapshot register core

This block is the register-access heart of a real-time clock. A live BCD time chain (hundredths of a second up to a two-digit year) advances on a tick derived from an oscillator enable. Software never touches the live chain directly. It works through a transfer interface that opens a transfer at a start address, moves bytes to or from a pointer that steps by one after each byte, and then closes the transfer. The bytes land in a bank of eight clock buffer registers and 24 general byte registers.

Opening a transfer photographs the live chain into the clock buffers. Closing a transfer commits the whole buffer bank back into the chain, but only if a clock register was written. A sticky halt flag stops the photograph from being taken. A battery-backup indication sets the flag, and software clears it. While the flag is set, reads keep returning the time of the last access. A clock write made in that state restores that stale time, together with the newly written field, into the chain. Every commit also restarts the tick prescaler.

Top module: `rtc_snap_core`

## Requirements
- R1: After reset the live chain reads, for addresses 0 to 7, hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and the halt flag is 0.
- R2: When a transfer opens with the halt flag clear, the eight live fields are copied into the clock buffers. Every read inside that transfer returns this copy, even if the chain advances before the transfer closes.
- R3: The byte pointer loads the start address when a transfer opens. It steps by one after each read or write and wraps from 0x1F to 0x00. A read returns its byte on rd_data one cycle later, with rd_valid high.
- R4: Closing a transfer that wrote any of addresses 0 to 7 loads all eight clock buffers into the chain. A clock field that was not written keeps the value it had when the transfer opened.
- R5: A transfer that writes only addresses 0x08 to 0x1F leaves the chain running undisturbed, and those addresses read back the plain 8-bit values written.
- R6: A commit clears the prescaler, so the next tick comes exactly TICK_DIV oscillator enables after the commit.
- R7: The halt flag reads as bit 6 of address 0x0C. It is set while vbat_on is high, and a write to 0x0C loads it from bit 6 of the written byte.
- R8: While the halt flag is set, opening a transfer leaves the clock buffers unchanged, so repeated reads return the time of the last access before the halt.
- R9: After 0 is written to the halt flag, the next transfer copies the live chain again.
- R10: A clock write while halted commits the frozen buffers, with the newly written field, into the chain.
- R11: On each tick the fields count in BCD: hundredths 00-99, seconds and minutes 00-59, hours 00-23, weekday 1-7, date 1 to month length (30 for months 4, 6, 9 and 11; 28 for month 2, or 29 when the year is divisible by 4; 31 otherwise), month 1-12, year 00-99.
- R12: When a commit and a tick fall in the same cycle, the committed value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle oscillator enable pulse (nominally 32768 Hz) |
| vbat_on | input | 1 | Battery-backup indication; sets the halt flag |
| xfer_start | input | 1 | Opens a transfer; snapshot point |
| start_addr | input | 5 | Pointer value loaded at transfer open |
| xfer_end | input | 1 | Closes a transfer; commit point |
| wr_en | input | 1 | Writes wr_data at the pointer, then steps the pointer |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Reads the byte at the pointer, then steps the pointer |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data holds a fresh read byte |

## Verification
The bench drives every date rollover that can go wrong: the end of February in a leap year and in a common year, a 30-day month, and the year wrap. A wrong month-length table or leap test shows up there as a date of 29, 30 or 31 where the next month should begin. A transfer keeps the chain ticking while it is open, so a design that commits on a general-register-only write visibly rolls the time backwards, and a design that re-reads the live chain mid-transfer returns a time that moves. The bench also lines up a tick with the closing cycle to catch a design that lets the tick win, and starts the prescaler part-way through its count before a commit to catch a design that keeps the old phase. The halt sequence freezes the time, writes a seconds field while halted and then clears the flag. A design that refreshes buffers while halted, or that merges live time into the commit, ends at a different hundredths value.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  localparam int NREG      = 32;
  localparam int AW        = $clog2(NREG);
  localparam int NCLK      = 8;
  localparam int CIW       = $clog2(NCLK);
  localparam int HALT_ADDR = 12;
  localparam int HALT_BIT  = 6;

  typedef logic [7:0]            byte_t;
  typedef logic [NCLK-1:0][7:0]  tbank_t;

  // field slots inside a time bank
  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_WDAY = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  function automatic byte_t bcd_next(input byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic bcd_leap(input byte_t y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic byte_t month_last(input byte_t m, input byte_t y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 328
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   osc_en,
  input  logic                   clr,
  output logic                   tick,
  output logic [$clog2(DIV)-1:0] cnt
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign tick = osc_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (osc_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_snap_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   load,
  input  tbank_t load_val,
  output tbank_t cnt_q
);
  tbank_t nxt;
  logic   c_sec, c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    c_sec  = tick   && (cnt_q[F_HUND] == 8'h99);
    c_min  = c_sec  && (cnt_q[F_SEC]  == 8'h59);
    c_hour = c_min  && (cnt_q[F_MIN]  == 8'h59);
    c_day  = c_hour && (cnt_q[F_HOUR] == 8'h23);
    c_mon  = c_day  && (cnt_q[F_DATE] == month_last(cnt_q[F_MON], cnt_q[F_YEAR]));
    c_year = c_mon  && (cnt_q[F_MON]  == 8'h12);

    nxt = cnt_q;
    if (tick)   nxt[F_HUND] = c_sec  ? 8'h00 : bcd_next(cnt_q[F_HUND]);
    if (c_sec)  nxt[F_SEC]  = c_min  ? 8'h00 : bcd_next(cnt_q[F_SEC]);
    if (c_min)  nxt[F_MIN]  = c_hour ? 8'h00 : bcd_next(cnt_q[F_MIN]);
    if (c_hour) nxt[F_HOUR] = c_day  ? 8'h00 : bcd_next(cnt_q[F_HOUR]);
    if (c_day)  nxt[F_WDAY] = (cnt_q[F_WDAY] == 8'h07) ? 8'h01 : bcd_next(cnt_q[F_WDAY]);
    if (c_day)  nxt[F_DATE] = c_mon  ? 8'h01 : bcd_next(cnt_q[F_DATE]);
    if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_next(cnt_q[F_MON]);
    if (c_year) nxt[F_YEAR] = (cnt_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_next(cnt_q[F_YEAR]);
  end

  // load has priority over the running increment
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      cnt_q[F_WDAY] <= 8'h01;
      cnt_q[F_DATE] <= 8'h01;
      cnt_q[F_MON]  <= 8'h01;
    end else if (load) begin
      cnt_q <= load_val;
    end else begin
      cnt_q <= nxt;
    end
  end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_snap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_start,
  input  logic [AW-1:0] start_addr,
  input  logic          xfer_end,
  input  logic          wr_en,
  input  byte_t         wr_data,
  input  logic          rd_en,
  input  logic          vbat_on,
  input  tbank_t        live,
  output tbank_t        buf_q,
  output logic          halt_q,
  output logic          commit,
  output byte_t         rd_data,
  output logic          rd_valid
);
  localparam logic [AW-1:0] CLK_TOP = AW'(NCLK);
  localparam logic [AW-1:0] HALT_A  = AW'(HALT_ADDR);

  logic [AW-1:0]   ptr;
  logic [NCLK-1:0] written;
  byte_t           gen_mem [NREG];
  byte_t           rd_mux;
  logic            is_clk;
  logic            do_wr, do_rd;

  assign is_clk = (ptr < CLK_TOP);
  assign do_wr  = wr_en && !xfer_start && !xfer_end;
  assign do_rd  = rd_en && !xfer_start && !xfer_end && !wr_en;
  assign commit = xfer_end && !xfer_start && (|written);

  // general registers: plain storage, no reset
  always_ff @(posedge clk) begin
    if (do_wr && !is_clk) gen_mem[ptr] <= wr_data;
  end

  always_comb begin
    if (is_clk) begin
      rd_mux = buf_q[ptr[CIW-1:0]];
    end else begin
      rd_mux = gen_mem[ptr];
      if (ptr == HALT_A) rd_mux[HALT_BIT] = halt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      written  <= '0;
      buf_q    <= '0;
      halt_q   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (xfer_start) begin
        ptr     <= start_addr;
        written <= '0;
        if (!halt_q) buf_q <= live;
      end else if (xfer_end) begin
        written <= '0;
      end else if (do_wr) begin
        if (is_clk) begin
          buf_q[ptr[CIW-1:0]]   <= wr_data;
          written[ptr[CIW-1:0]] <= 1'b1;
        end
        if (ptr == HALT_A) halt_q <= wr_data[HALT_BIT];
        ptr <= ptr + 1'b1;
      end else if (do_rd) begin
        rd_data  <= rd_mux;
        rd_valid <= 1'b1;
        ptr      <= ptr + 1'b1;
      end
      if (vbat_on) halt_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_snap_core.sv
module rtc_snap_core
  import rtc_snap_pkg::*;
#(
  parameter int TICK_DIV = 328
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          vbat_on,
  input  logic          xfer_start,
  input  logic [AW-1:0] start_addr,
  input  logic          xfer_end,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);
  localparam int PCW = $clog2(TICK_DIV);

  tbank_t         live, bufs;
  logic           tick, commit, halt;
  logic [PCW-1:0] pre_cnt;
  logic           pre_idle;

  assign pre_idle = (pre_cnt == '0);

  rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .osc_en(osc_en), .clr(commit),
    .tick(tick), .cnt(pre_cnt)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .tick(tick), .load(commit),
    .load_val(bufs), .cnt_q(live)
  );

  rtc_reg_bank u_bank (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .start_addr(start_addr),
    .xfer_end(xfer_end), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .vbat_on(vbat_on), .live(live), .buf_q(bufs), .halt_q(halt),
    .commit(commit), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/rtc_snap_sva.sv
module rtc_snap_sva
  import rtc_snap_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   xfer_start,
  input logic   xfer_end,
  input logic   vbat_on,
  input logic   halt,
  input logic   commit,
  input logic   tick,
  input logic   pre_idle,
  input tbank_t live,
  input tbank_t bufs
);
  p_snapshot_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && !halt) |=> (bufs == $past(live)));

  p_commit_all_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (live == $past(bufs)));

  p_no_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && !commit && !tick) |=> (live == $past(live)));

  p_div_clear_r6: assert property (@(posedge clk) disable iff (rst)
    commit |=> pre_idle);

  p_halt_set_r7: assert property (@(posedge clk) disable iff (rst)
    vbat_on |=> halt);

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && halt) |=> $stable(bufs));
endmodule

bind rtc_snap_core rtc_snap_sva u_sva (
  .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_end(xfer_end),
  .vbat_on(vbat_on), .halt(halt), .commit(commit), .tick(tick),
  .pre_idle(pre_idle), .live(live), .bufs(bufs)
);

// File: tb/rtc_snap_core_tb_top.sv
`timescale 1ns/1ps
module rtc_snap_core_tb_top;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0, vbat_on = 1'b0;
  logic       xfer_start = 1'b0, xfer_end = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] start_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int    n_checks = 0;
  int    n_fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rtc_snap_core #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rst(rst), .osc_en(osc_en), .vbat_on(vbat_on),
    .xfer_start(xfer_start), .start_addr(start_addr), .xfer_end(xfer_end),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [63:0] mk(input logic [7:0] h, s, mi, hr, wd, dt, mo, yr);
    return {yr, mo, dt, wd, hr, mi, s, h};
  endfunction

  // monitor: pops expected bytes as read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R3: unexpected read byte %h, expected none", rd_data);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fails++;
          $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic t_start(input logic [4:0] a);
    @(negedge clk); xfer_start = 1'b1; start_addr = a;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic t_end(input logic with_osc);
    @(negedge clk); xfer_end = 1'b1; osc_en = with_osc;
    @(negedge clk); xfer_end = 1'b0; osc_en = 1'b0;
  endtask

  task automatic t_wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_rd(input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic osc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  task automatic rd_time(input logic [63:0] v, input string t);
    t_start(5'h00);
    for (int i = 0; i < 8; i++) t_rd(v[8*i +: 8], t);
    t_end(1'b0);
  endtask

  task automatic wr_time(input logic [63:0] v);
    t_start(5'h00);
    for (int i = 0; i < 8; i++) t_wr(v[8*i +: 8]);
    t_end(1'b0);
  endtask

  task automatic set_tick(input logic [63:0] vin, input logic [63:0] vexp, input string t);
    wr_time(vin);
    osc(TDIV);
    rd_time(vexp, t);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: cycles=200000 expected completion earlier");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    rd_time(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R1");

    // R4: full write; prescaler left part-way beforehand
    osc(2);
    wr_time(mk(8'h50, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24));
    rd_time(mk(8'h50, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24), "R4");
    // R6: commit restarted the divider
    osc(TDIV - 1);
    rd_time(mk(8'h50, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24), "R6");
    osc(1);
    rd_time(mk(8'h51, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24), "R6");

    // R4: single-field write keeps the others
    t_start(5'h00); t_wr(8'h99); t_end(1'b0);
    rd_time(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24), "R4");
    // R11: leap February 28 -> 29, weekday 7 -> 1
    osc(TDIV);
    rd_time(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h29, 8'h02, 8'h24), "R11");
    // R11: leap February 29 -> March 1
    t_start(5'h00); t_wr(8'h99); t_wr(8'h59); t_wr(8'h59); t_wr(8'h23); t_end(1'b0);
    osc(TDIV);
    rd_time(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h24), "R11");
    // R11: common-year February, 30-day month, year wrap
    set_tick(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23),
             mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23), "R11");
    set_tick(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h25),
             mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h25), "R11");
    set_tick(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99),
             mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R11");

    // R3 and R5: general writes, wrap to 0x00, chain ticks inside the transfer
    t_start(5'h1E); t_wr(8'h11); t_wr(8'h22); t_rd(8'h00, "R3");
    osc(TDIV);
    t_end(1'b0);
    t_start(5'h1E); t_rd(8'h11, "R5"); t_rd(8'h22, "R5"); t_rd(8'h01, "R3 R5"); t_end(1'b0);
    rd_time(mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R5");

    // R12: tick lands on the commit cycle
    t_start(5'h00); t_wr(8'h40);
    osc(TDIV - 1);
    t_end(1'b1);
    rd_time(mk(8'h40, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R12");
    osc(TDIV - 1);
    rd_time(mk(8'h40, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R6");
    osc(1);

    // R2: snapshot holds while the chain advances
    t_start(5'h00);
    osc(TDIV);
    for (int i = 0; i < 8; i++)
      t_rd(mk(8'h41, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00) >> (8*i), "R2");
    t_end(1'b0);
    rd_time(mk(8'h42, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R2");

    // R7: halt flag at bit 6 of 0x0C
    t_start(5'h0C); t_wr(8'h00); t_end(1'b0);
    t_start(5'h0C); t_rd(8'h00, "R7"); t_end(1'b0);
    @(negedge clk); vbat_on = 1'b1;
    @(negedge clk); vbat_on = 1'b0;
    t_start(5'h0C); t_rd(8'h40, "R7"); t_end(1'b0);

    // R8: frozen reads while the chain keeps going
    osc(TDIV);
    rd_time(mk(8'h42, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R8");
    osc(TDIV);
    rd_time(mk(8'h42, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R8");

    // R10: seconds written while halted restores stale time
    t_start(5'h01); t_wr(8'h46); t_end(1'b0);
    osc(TDIV);
    // R9: clear halt, next transfer sees live time
    t_start(5'h0C); t_wr(8'h00); t_end(1'b0);
    rd_time(mk(8'h43, 8'h46, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00), "R9 R10");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R3: pending reads=%0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule